// File: doc/BRIEF.md
# HDLC Frame Status Queue

This block keeps one record for each received HDLC/SDLC frame so that a DMA engine can keep moving frame data into memory while a CPU checks earlier frames later. While the feature is enabled, a 14-bit counter counts the receive byte strobes of the current frame. When the end-of-frame strobe marks the closing flag, the block writes the count and the five frame status bits sampled at that moment into a 10-entry first-in first-out queue as one 19-bit entry. The counter then starts again from zero.

Software reads the oldest entry through two read ports. A low-count read returns count bits 7:0 and leaves the entry in place. A high read returns count bits 13:8 together with the status bits, then removes the entry. Full, empty, level and a sticky overflow flag show the state of the queue. Clearing the enable flushes the queue, the counter and the overflow flag. This queue is independent of the receive data byte FIFO.

Top module: `frame_stat_queue`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `level` is 0, `overflow` is 0, and both read data outputs are 0.
- R2: While `en` is 1, each cycle with `byte_stb` high adds one to the frame count. A cycle with `eof_stb` high writes {`eof_status`, count} as an entry. A byte strobe in the same cycle as `eof_stb` is included in that entry's count.
- R3: Every end-of-frame clears the counter, whether its entry was stored or dropped, so the next frame counts from 0.
- R4: The frame count saturates at 16383 and does not wrap.
- R5: A `rd_lo_stb` pulse makes `rd_lo_data` equal count bits 7:0 of the oldest entry one cycle later. It does not remove the entry.
- R6: A `rd_hi_stb` pulse makes `rd_hi_data` equal {status[4:0] in bits 10:6, count[13:8] in bits 5:0} of the oldest entry one cycle later, and removes that entry.
- R7: Entries are read back in the order they were written. The queue holds 10 entries. `level` gives the number held, and `full` is 1 exactly when 10 are held.
- R8: An end-of-frame while the queue is full, with no high read in the same cycle, drops the entry and sets `overflow`. `overflow` stays set until `en` is cleared. If a high read occurs in the same cycle, the new entry is accepted and the level stays at 10.
- R9: While `en` is 0, the queue is empty, the counter and `overflow` are cleared, strobes have no effect, and both read outputs return 0.
- R10: A high read of an empty queue returns 0 and leaves `level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Feature enable; low flushes all state |
| byte_stb | input | 1 | One received byte of the current frame |
| eof_stb | input | 1 | Closing flag of the current frame received |
| eof_status | input | 5 | Frame status/error bits at end of frame |
| rd_lo_stb | input | 1 | Read of the low count register |
| rd_hi_stb | input | 1 | Read of the high count and status register; pops |
| rd_lo_data | output | 8 | Count bits 7:0 of the oldest entry |
| rd_hi_data | output | 11 | Status bits 10:6, count bits 13:8 in 5:0 |
| full | output | 1 | Queue holds 10 entries |
| empty | output | 1 | Queue holds no entries |
| level | output | 4 | Number of entries held |
| overflow | output | 1 | Sticky: a frame record was dropped |

## Verification
The hardest case to reach is an end-of-frame that arrives while the queue is full. The outcome depends on whether a high read lands in that same cycle, because a pop makes room and a plain write is dropped. The stimulus first fills all ten slots with frames of distinct lengths. It then sends one frame whose closing strobe coincides with a high read, and after that one frame with no read. The results show that the first frame is kept and the second is dropped with the overflow flag set. The saturation boundary is reached by streaming more than 16383 byte strobes into a single frame.

// File: rtl/fsq_pkg.sv
// Package: shared widths and entry layout for the frame status queue.
// Assumes a count field of at least 8 bits so the low register is full width.
package fsq_pkg;
    localparam int FSQ_CNT_W  = 14;
    localparam int FSQ_STAT_W = 5;
    localparam int FSQ_LO_W   = 8;
    localparam int FSQ_HI_W   = FSQ_CNT_W - FSQ_LO_W + FSQ_STAT_W;
    localparam int FSQ_ENT_W  = FSQ_CNT_W + FSQ_STAT_W;

    typedef struct packed {
        logic [FSQ_STAT_W-1:0] status;
        logic [FSQ_CNT_W-1:0]  count;
    } fsq_entry_t;
endpackage

// File: rtl/fsq_byte_counter.sv
// Module: per-frame byte counter.
// Counts byte strobes and saturates at the top value. The output includes a byte
// that arrives in the same cycle, so the value can be written on end of frame.
// Clears after every end of frame and whenever the feature is disabled.
module fsq_byte_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             byte_stb,
    input  logic             eof_stb,
    output logic [CNT_W-1:0] frame_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Next count value, held at the top instead of wrapping.
    always_comb begin
        frame_cnt = cnt_q;
        if (byte_stb && (cnt_q != CNT_MAX)) begin
            frame_cnt = cnt_q + 1'b1;
        end
    end

    // Count register: restarts on end of frame or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (eof_stb) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= frame_cnt;
        end
    end
endmodule

// File: rtl/fsq_entry_store.sv
// Module: circular buffer for frame status entries, with a depth that need not be
// a power of two. A write is accepted when there is room or when a pop happens in
// the same cycle. A rejected write raises drop for that cycle. flush empties the buffer.
module fsq_entry_store #(
    parameter int DEPTH = 10,
    parameter int EW    = 19,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic [EW-1:0] wr_data,
    output logic [EW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level,
    output logic          drop
);
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] lvl_q;
    logic          push_ok, pop_ok;

    // Pointer advance with wrap at the last slot.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide which operations take effect this cycle.
    always_comb begin
        full    = (lvl_q == LW'(DEPTH));
        empty   = (lvl_q == '0);
        pop_ok  = pop_req && !empty;
        push_ok = push_req && (!full || pop_ok);
        drop    = push_req && !push_ok;
        head    = mem[rd_ptr];
        level   = lvl_q;
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            lvl_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end
endmodule

// File: rtl/fsq_read_port.sv
// Module: the two read registers. A low read captures count bits 7:0. A high read
// captures the upper count bits and status, and requests a pop. Data appears one
// cycle after the strobe. Empty reads and disabled state return zero.
module fsq_read_port
    import fsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                rd_lo_stb,
    input  logic                rd_hi_stb,
    input  logic                empty,
    input  fsq_entry_t          head,
    output logic [FSQ_LO_W-1:0] rd_lo_data,
    output logic [FSQ_HI_W-1:0] rd_hi_data,
    output logic                pop_req
);
    // A high read removes the oldest entry.
    always_comb begin
        pop_req = en && rd_hi_stb;
    end

    // Read data capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            rd_lo_data <= '0;
            rd_hi_data <= '0;
        end else begin
            if (rd_lo_stb) begin
                rd_lo_data <= empty ? '0 : head.count[FSQ_LO_W-1:0];
            end
            if (rd_hi_stb) begin
                rd_hi_data <= empty ? '0 : {head.status, head.count[FSQ_CNT_W-1:FSQ_LO_W]};
            end
        end
    end
endmodule

// File: rtl/frame_stat_queue.sv
// Module: frame status queue top. Counts the bytes of each frame and writes
// {status, count} on end of frame into a small queue that software reads through
// two registers. Assumes the strobes are single-cycle pulses in the clk domain.
// Clearing en flushes the queue and clears the counter and overflow.
module frame_stat_queue
    import fsq_pkg::*;
#(
    parameter int DEPTH = 10,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  byte_stb,
    input  logic                  eof_stb,
    input  logic [FSQ_STAT_W-1:0] eof_status,
    input  logic                  rd_lo_stb,
    input  logic                  rd_hi_stb,
    output logic [FSQ_LO_W-1:0]   rd_lo_data,
    output logic [FSQ_HI_W-1:0]   rd_hi_data,
    output logic                  full,
    output logic                  empty,
    output logic [LW-1:0]         level,
    output logic                  overflow
);
    logic [FSQ_CNT_W-1:0] frame_cnt;
    fsq_entry_t           new_ent, head_ent;
    logic [FSQ_ENT_W-1:0] head_raw;
    logic                 pop_req, drop, push_req;

    fsq_byte_counter #(.CNT_W(FSQ_CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .byte_stb  (byte_stb),
        .eof_stb   (eof_stb),
        .frame_cnt (frame_cnt)
    );

    // Form the entry to be written at end of frame.
    always_comb begin
        new_ent.status = eof_status;
        new_ent.count  = frame_cnt;
        push_req       = en && eof_stb;
        head_ent       = fsq_entry_t'(head_raw);
    end

    fsq_entry_store #(.DEPTH(DEPTH), .EW(FSQ_ENT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!en),
        .push_req (push_req),
        .pop_req  (pop_req),
        .wr_data  (new_ent),
        .head     (head_raw),
        .full     (full),
        .empty    (empty),
        .level    (level),
        .drop     (drop)
    );

    fsq_read_port u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .rd_lo_stb  (rd_lo_stb),
        .rd_hi_stb  (rd_hi_stb),
        .empty      (empty),
        .head       (head_ent),
        .rd_lo_data (rd_lo_data),
        .rd_hi_data (rd_hi_data),
        .pop_req    (pop_req)
    );

    // Sticky overflow: set on a dropped entry, cleared only by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/fsq_checker.sv
// Module: temporal checks for the frame status queue, attached by bind.
module fsq_checker #(
    parameter int DEPTH = 10,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          eof_stb,
    input logic          rd_hi_stb,
    input logic [7:0]    rd_lo_data,
    input logic [10:0]   rd_hi_data,
    input logic          full,
    input logic          empty,
    input logic [LW-1:0] level,
    input logic          overflow
);
    // R7
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level <= LW'(DEPTH)) && !(full && empty));

    // R6
    pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && rd_hi_stb && !eof_stb && !empty |=> level == $past(level) - 1'b1);

    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && eof_stb && full && !rd_hi_stb |=> overflow && full);

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && overflow |=> overflow);

    // R9
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> empty && !overflow && rd_lo_data == '0 && rd_hi_data == '0);

    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && rd_hi_stb && empty && !eof_stb |=> rd_hi_data == '0 && empty);
endmodule

bind frame_stat_queue fsq_checker #(.DEPTH(DEPTH)) u_fsq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .eof_stb    (eof_stb),
    .rd_hi_stb  (rd_hi_stb),
    .rd_lo_data (rd_lo_data),
    .rd_hi_data (rd_hi_data),
    .full       (full),
    .empty      (empty),
    .level      (level),
    .overflow   (overflow)
);

// File: tb/frame_stat_queue_bench.sv
`timescale 1ns/1ps
module frame_stat_queue_bench;
    localparam int DEPTH = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        byte_stb = 1'b0;
    logic        eof_stb = 1'b0;
    logic [4:0]  eof_status = '0;
    logic        rd_lo_stb = 1'b0;
    logic        rd_hi_stb = 1'b0;
    logic [7:0]  rd_lo_data;
    logic [10:0] rd_hi_data;
    logic        full, empty, overflow;
    logic [3:0]  level;

    int checks = 0;
    int errors = 0;
    logic [18:0] sbq[$];
    logic        exp_ovf = 1'b0;

    always #2 clk = ~clk;

    frame_stat_queue u_frame_stat_queue (
        .clk(clk), .rst_n(rst_n), .en(en), .byte_stb(byte_stb), .eof_stb(eof_stb),
        .eof_status(eof_status), .rd_lo_stb(rd_lo_stb), .rd_hi_stb(rd_hi_stb),
        .rd_lo_data(rd_lo_data), .rd_hi_data(rd_hi_data), .full(full),
        .empty(empty), .level(level), .overflow(overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard model of a written entry.
    task automatic model_push(input int nbytes, input logic [4:0] st);
        int c;
        c = (nbytes > 16383) ? 16383 : nbytes;
        if (sbq.size() < DEPTH) sbq.push_back({st, c[13:0]});
        else exp_ovf = 1'b1;
    endtask

    // Driver: one frame of nbytes, optional byte on the closing cycle, optional high read.
    task automatic send_frame(input int nbytes, input logic [4:0] st,
                              input bit merge, input bit hi_too);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            byte_stb = 1'b1;
            if (merge && i == nbytes - 1) begin
                eof_stb = 1'b1; eof_status = st; rd_hi_stb = hi_too;
            end
        end
        @(negedge clk);
        byte_stb = 1'b0;
        if (!merge || nbytes == 0) begin
            eof_stb = 1'b1; eof_status = st; rd_hi_stb = hi_too;
            @(negedge clk);
        end
        eof_stb = 1'b0; rd_hi_stb = 1'b0;
    endtask

    task automatic pulse_lo();
        @(negedge clk); rd_lo_stb = 1'b1;
        @(negedge clk); rd_lo_stb = 1'b0;
    endtask

    task automatic pulse_hi();
        @(negedge clk); rd_hi_stb = 1'b1;
        @(negedge clk); rd_hi_stb = 1'b0;
    endtask

    // Monitor: reads the oldest entry and compares it with the scoreboard head.
    task automatic read_entry(input string req);
        logic [18:0] e;
        e = sbq.pop_front();
        pulse_lo();
        chk({req, " R5 low byte"}, int'(rd_lo_data), int'(e[7:0]));
        pulse_hi();
        chk({req, " R6 high bits"}, int'(rd_hi_data), int'({e[18:14], e[13:8]}));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [18:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", empty, 1); chk("R1 full", full, 0);
        chk("R1 level", level, 0); chk("R1 overflow", overflow, 0);
        chk("R1 lo", rd_lo_data, 0); chk("R1 hi", rd_hi_data, 0);

        en = 1'b1;
        // R2 two frames, the second with a byte on the closing cycle
        send_frame(5, 5'b10101, 0, 0);  model_push(5, 5'b10101);
        send_frame(300, 5'b00011, 1, 0); model_push(300, 5'b00011);
        chk("R7 level two", level, 2);
        read_entry("R2 frame a");
        read_entry("R2 frame b");

        // R10 high read of an empty queue
        pulse_hi();
        chk("R10 empty read data", rd_hi_data, 0);
        chk("R10 level", level, 0);

        // R5 low reads do not pop
        send_frame(7, 5'b01000, 0, 0); model_push(7, 5'b01000);
        pulse_lo(); pulse_lo();
        chk("R5 level after low reads", level, 1);
        read_entry("R5 frame");

        // R7 fill to capacity in order
        for (int i = 0; i < DEPTH; i++) begin
            send_frame(i + 2, 5'(i), 0, 0); model_push(i + 2, 5'(i));
        end
        chk("R7 full", full, 1); chk("R7 level ten", level, 10);

        // R8 write while full with a simultaneous high read is accepted
        e = sbq.pop_front();
        send_frame(4, 5'b11111, 0, 1); model_push(4, 5'b11111);
        chk("R8 pop data at full", rd_hi_data, int'({e[18:14], e[13:8]}));
        chk("R8 level kept", level, 10);
        chk("R8 no overflow", overflow, 0);

        // R8 write while full without a read is dropped
        send_frame(6, 5'b10000, 0, 0); model_push(6, 5'b10000);
        chk("R8 overflow set", overflow, int'(exp_ovf));
        chk("R8 level after drop", level, 10);
        for (int i = 0; i < DEPTH; i++) read_entry("R7 order");
        chk("R8 overflow sticky", overflow, 1);

        // R3 counter restarted after the dropped frame
        send_frame(3, 5'b00001, 0, 0); model_push(3, 5'b00001);
        read_entry("R3 restart");

        // R9 disable flushes and ignores strobes
        send_frame(2, 5'b00010, 0, 0);
        repeat (5) begin @(negedge clk); byte_stb = 1'b1; end
        @(negedge clk); byte_stb = 1'b0; en = 1'b0;
        @(negedge clk);
        chk("R9 empty", empty, 1); chk("R9 overflow", overflow, 0);
        send_frame(4, 5'b00100, 0, 0);
        pulse_hi();
        chk("R9 level ignored", level, 0); chk("R9 hi zero", rd_hi_data, 0);
        pulse_lo();
        chk("R9 lo zero", rd_lo_data, 0);
        en = 1'b1; exp_ovf = 1'b0; sbq.delete();
        send_frame(2, 5'b00110, 0, 0); model_push(2, 5'b00110);
        read_entry("R9 count cleared");

        // R4 saturation, then R3 restart
        send_frame(16390, 5'b01010, 0, 0); model_push(16390, 5'b01010);
        read_entry("R4 saturate");
        send_frame(2, 5'b00101, 0, 0); model_push(2, 5'b00101);
        read_entry("R3 after saturate");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule